// File: doc/BRIEF.md
# Bidirectional Mailbox Interrupt Register File

This block is a pair of register maps that lets a host bus and a local bus pass short messages and raise interrupts on each other. Each side owns a write-capable set of mailboxes that the other side can only read. The host fills the inbound mailboxes, and the local side fills the outbound mailboxes. Writing a mailbox also sets the matching bit in the status register of the receiving side. That side reads the message and then clears the bit.

Each side has an interrupt status register, which clears when 1 is written to a bit, and an enable register of the same shape. The host interrupt line is active low. It is also held inactive by a global disable input, which models the disable bit of the host command register. The local interrupt line is active high. The mailbox count per direction is a build parameter with the value 1 or 8. Both sides use the same register offsets. Reads are registered and return their data one cycle after the request.

Top module: `mbox_irq_regfile`

## Requirements
- R1: After a synchronous active-low reset, all mailboxes, status bits and enable bits are 0. `h_int_n` is 1, `l_irq` is 0, and both read-data buses are 0.
- R2: Inbound mailbox N sits at offset 0x800 + 4·N, for N below the mailbox count. A host write stores the data, and both sides read it back at that offset. A local write to that offset has no effect.
- R3: A host write to inbound mailbox N sets bit N of the local status register. The bit reads as 1 from the first cycle after the write.
- R4: Outbound mailbox N sits at offset 0x900 + 4·N. A local write stores the data and sets bit N of the host status register. Both sides read the data back. A host write to that offset has no effect.
- R5: Each status register sits at offset 0x040 of its own side. Writing 1 to a bit clears that bit, and writing 0 leaves it alone. If a clear and a set of the same bit happen in the same cycle, the set wins and the bit stays 1.
- R6: Each enable register sits at offset 0x050 of its own side. Only bits below the mailbox count can be written. All higher bits always read 0.
- R7: `h_int_n` is 0 when some host status bit and its enable bit are both 1 and `h_int_disable` is 0. Otherwise `h_int_n` is 1. A change on `h_int_disable` shows on `h_int_n` in the same cycle.
- R8: `l_irq` is 1 exactly when some local status bit and its enable bit are both 1.
- R9: When a side asserts its read strobe, that side's read-data bus shows the addressed value after the next clock edge. It shows 0 in cycles without a read. A read or write at an unmapped offset returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | REG_W | Host write data |
| h_rdata | output | REG_W | Host read data, registered |
| h_int_disable | input | 1 | Global host interrupt disable |
| h_int_n | output | 1 | Host interrupt, active low |
| l_wr_en | input | 1 | Local write strobe |
| l_rd_en | input | 1 | Local read strobe |
| l_addr | input | ADDR_W | Local byte offset |
| l_wdata | input | REG_W | Local write data |
| l_rdata | output | REG_W | Local read data, registered |
| l_irq | output | 1 | Local interrupt, active high |

## Verification
Every stored value, whether a mailbox word, a status bit or an enable bit, changes on the clock edge that accepts the write. The interrupt lines follow on that edge with no extra register, and `h_int_disable` reaches `h_int_n` with no register at all. Read data appears on the edge that accepts the read and returns to 0 one edge later. The bench drives inputs on falling edges and samples on the next falling edge. A read result is therefore caught in the single cycle it is valid, and every interrupt level is seen after exactly one edge. For the set-against-clear case, both sides drive in the same cycle.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the mailbox interrupt register file.
// Assumes a byte-offset address of 12 bits and at most 8 mailboxes per direction.
package mbox_pkg;

    localparam int unsigned MAX_MBOX   = 8;
    localparam int unsigned SLOT_W     = 3;
    localparam int unsigned OFF_W      = 12;

    localparam logic [OFF_W-1:0] OFF_STAT    = 12'h040;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 12'h050;
    localparam logic [OFF_W-1:0] OFF_IN_BASE = 12'h800;
    localparam logic [OFF_W-1:0] OFF_OUT_BASE = 12'h900;

    // Result of decoding one offset on either side.
    typedef struct packed {
        logic              stat;
        logic              enable;
        logic              inbox;
        logic              outbox;
        logic [SLOT_W-1:0] slot;
    } dec_t;

endpackage

// File: rtl/mbox_addr_dec.sv
// Offset decoder for one side of the register file.
// Marks which register an offset selects and which mailbox slot it names.
// Assumes word-aligned offsets. Slots at or above NUM_MBOX decode as unmapped.
module mbox_addr_dec
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NUM_MBOX);

    logic              aligned;
    logic [SLOT_W-1:0] slot;
    logic              slot_ok;

    // Split the offset into alignment, slot number and slot range check.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        slot    = addr[4:2];
        slot_ok = ({1'b0, slot} < SLOT_LIMIT);
    end

    // Compare the offset against each register window.
    always_comb begin
        dec.stat   = (addr == OFF_STAT);
        dec.enable = (addr == OFF_ENABLE);
        dec.inbox  = aligned && slot_ok && (addr[ADDR_W-1:5] == OFF_IN_BASE[ADDR_W-1:5]);
        dec.outbox = aligned && slot_ok && (addr[ADDR_W-1:5] == OFF_OUT_BASE[ADDR_W-1:5]);
        dec.slot   = slot;
    end

endmodule

// File: rtl/mbox_store.sv
// Storage for one direction of mailboxes, with a single write port.
// Each slot holds one data word. A write to a slot also raises that slot's
// set pulse for one cycle, and the receiving side's status bank consumes it.
module mbox_store #(
    parameter int unsigned NUM_MBOX = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_MBOX*DATA_W-1:0]   q_flat,
    output logic [NUM_MBOX-1:0]          set_pulse
);

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
        logic              hit;
        logic [DATA_W-1:0] word_q;

        // Select this slot when the write targets it.
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        // Hold the slot word. It clears on reset and loads on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '0;
            else if (hit) word_q <= wr_data;
        end

        assign q_flat[g*DATA_W +: DATA_W] = word_q;
        assign set_pulse[g]               = hit;
    end

endmodule

// File: rtl/mbox_irq_bank.sv
// Interrupt status and enable pair for one side.
// Status bits set from the set vector and clear when the owner writes 1 to them.
// A set beats a clear in the same cycle. Only NUM_BITS enable bits exist.
// The registers read back zero-extended to REG_W bits.
module mbox_irq_bank #(
    parameter int unsigned NUM_BITS = 8,
    parameter int unsigned REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] set_vec,
    input  logic                clr_wr,
    input  logic                en_wr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    stat_q,
    output logic [REG_W-1:0]    en_q,
    output logic                pending
);

    localparam int unsigned PAD_W = REG_W - NUM_BITS;

    logic [NUM_BITS-1:0] stat_r;
    logic [NUM_BITS-1:0] en_r;
    logic [NUM_BITS-1:0] clr_mask;

    // Build the write-1-to-clear mask from the owner's write.
    assign clr_mask = clr_wr ? wdata[NUM_BITS-1:0] : '0;

    // Update the status bits. The clear is applied first, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_r <= '0;
        else        stat_r <= (stat_r & ~clr_mask) | set_vec;
    end

    // Load the implemented enable bits and drop the rest of the write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_r <= '0;
        else if (en_wr) en_r <= wdata[NUM_BITS-1:0];
    end

    assign stat_q  = {{PAD_W{1'b0}}, stat_r};
    assign en_q    = {{PAD_W{1'b0}}, en_r};
    assign pending = |(stat_r & en_r);

endmodule

// File: rtl/mbox_irq_regfile.sv
// Top of the bidirectional mailbox interrupt register file.
// The host writes inbound mailboxes, and the local side writes outbound ones.
// Each write sets a status bit on the other side. Both sides use the same
// offsets, and each has its own status and enable registers.
// Assumes NUM_MBOX is 1 or 8 and that both sides share one clock.
module mbox_irq_regfile
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 8,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REG_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic              h_rd_en,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [REG_W-1:0]  h_wdata,
    output logic [REG_W-1:0]  h_rdata,
    input  logic              h_int_disable,
    output logic              h_int_n,
    input  logic              l_wr_en,
    input  logic              l_rd_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [REG_W-1:0]  l_wdata,
    output logic [REG_W-1:0]  l_rdata,
    output logic              l_irq
);

    localparam int unsigned IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

    dec_t h_dec, l_dec;

    logic [NUM_MBOX*REG_W-1:0] in_flat, out_flat;
    logic [NUM_MBOX-1:0]       in_set, out_set;
    logic [REG_W-1:0]          hst_stat, hst_en, lcl_stat, lcl_en;
    logic                      hst_pending, lcl_pending;
    logic [IDX_W-1:0]          h_idx, l_idx;
    logic [REG_W-1:0]          h_rd_mux, l_rd_mux;

    mbox_addr_dec #(.NUM_MBOX(NUM_MBOX), .ADDR_W(ADDR_W)) u_h_dec (
        .addr (h_addr),
        .dec  (h_dec)
    );

    mbox_addr_dec #(.NUM_MBOX(NUM_MBOX), .ADDR_W(ADDR_W)) u_l_dec (
        .addr (l_addr),
        .dec  (l_dec)
    );

    assign h_idx = h_dec.slot[IDX_W-1:0];
    assign l_idx = l_dec.slot[IDX_W-1:0];

    // Inbound mailboxes: only the host writes them.
    mbox_store #(.NUM_MBOX(NUM_MBOX), .DATA_W(REG_W), .IDX_W(IDX_W)) u_inbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (h_wr_en && h_dec.inbox),
        .wr_idx    (h_idx),
        .wr_data   (h_wdata),
        .q_flat    (in_flat),
        .set_pulse (in_set)
    );

    // Outbound mailboxes: only the local side writes them.
    mbox_store #(.NUM_MBOX(NUM_MBOX), .DATA_W(REG_W), .IDX_W(IDX_W)) u_outbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (l_wr_en && l_dec.outbox),
        .wr_idx    (l_idx),
        .wr_data   (l_wdata),
        .q_flat    (out_flat),
        .set_pulse (out_set)
    );

    // Host status: outbound writes set the bits, and host writes clear them.
    mbox_irq_bank #(.NUM_BITS(NUM_MBOX), .REG_W(REG_W)) u_hst_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (out_set),
        .clr_wr  (h_wr_en && h_dec.stat),
        .en_wr   (h_wr_en && h_dec.enable),
        .wdata   (h_wdata),
        .stat_q  (hst_stat),
        .en_q    (hst_en),
        .pending (hst_pending)
    );

    // Local status: inbound writes set the bits, and local writes clear them.
    mbox_irq_bank #(.NUM_BITS(NUM_MBOX), .REG_W(REG_W)) u_lcl_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (in_set),
        .clr_wr  (l_wr_en && l_dec.stat),
        .en_wr   (l_wr_en && l_dec.enable),
        .wdata   (l_wdata),
        .stat_q  (lcl_stat),
        .en_q    (lcl_en),
        .pending (lcl_pending)
    );

    // Select the host read value. Unmapped offsets give 0.
    always_comb begin
        h_rd_mux = '0;
        if (h_dec.stat)        h_rd_mux = hst_stat;
        else if (h_dec.enable) h_rd_mux = hst_en;
        else if (h_dec.inbox)  h_rd_mux = in_flat[h_idx*REG_W +: REG_W];
        else if (h_dec.outbox) h_rd_mux = out_flat[h_idx*REG_W +: REG_W];
    end

    // Select the local read value. Unmapped offsets give 0.
    always_comb begin
        l_rd_mux = '0;
        if (l_dec.stat)        l_rd_mux = lcl_stat;
        else if (l_dec.enable) l_rd_mux = lcl_en;
        else if (l_dec.inbox)  l_rd_mux = in_flat[l_idx*REG_W +: REG_W];
        else if (l_dec.outbox) l_rd_mux = out_flat[l_idx*REG_W +: REG_W];
    end

    // Register host read data. The bus shows 0 when there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n)       h_rdata <= '0;
        else if (h_rd_en) h_rdata <= h_rd_mux;
        else              h_rdata <= '0;
    end

    // Register local read data. The bus shows 0 when there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n)       l_rdata <= '0;
        else if (l_rd_en) l_rdata <= l_rd_mux;
        else              l_rdata <= '0;
    end

    assign h_int_n = ~(hst_pending & ~h_int_disable);
    assign l_irq   = lcl_pending;

endmodule

// File: rtl/mbox_irq_regfile_chk.sv
// Assertion checker for mbox_irq_regfile. It is attached by the bind at the end.
// It watches both bus ports and the two status registers.
module mbox_irq_regfile_chk
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 8,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REG_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr_en,
    input logic              h_rd_en,
    input logic [ADDR_W-1:0] h_addr,
    input logic [REG_W-1:0]  h_rdata,
    input logic              h_int_disable,
    input logic              h_int_n,
    input logic              l_wr_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic [REG_W-1:0]  l_wdata,
    input logic              l_rd_en,
    input logic [REG_W-1:0]  l_rdata,
    input logic              l_irq,
    input logic [REG_W-1:0]  hst_stat,
    input logic [REG_W-1:0]  lcl_stat
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (h_int_n && !l_irq && h_rdata == '0 && l_rdata == '0));

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_bit
        // R3
        inbox_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (h_wr_en && h_addr == OFF_IN_BASE + ADDR_W'(4*i)) |=> lcl_stat[i]);

        // R4
        outbox_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (l_wr_en && l_addr == OFF_OUT_BASE + ADDR_W'(4*i)) |=> hst_stat[i]);

        // R5
        lcl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (l_wr_en && l_addr == OFF_STAT && l_wdata[i]
             && !(h_wr_en && h_addr == OFF_IN_BASE + ADDR_W'(4*i))) |=> !lcl_stat[i]);
    end

    // R6
    enable_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && h_addr == OFF_ENABLE) |=> ((h_rdata >> NUM_MBOX) == '0));

    // R7
    host_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_int_disable |-> h_int_n);

    // R8
    lcl_irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_irq |-> (lcl_stat != '0));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_en |=> (l_rdata == '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && h_addr[ADDR_W-1:8] == '0 && h_addr != OFF_STAT && h_addr != OFF_ENABLE)
        |=> (h_rdata == '0));

endmodule

bind mbox_irq_regfile mbox_irq_regfile_chk #(
    .NUM_MBOX (NUM_MBOX),
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .h_wr_en       (h_wr_en),
    .h_rd_en       (h_rd_en),
    .h_addr        (h_addr),
    .h_rdata       (h_rdata),
    .h_int_disable (h_int_disable),
    .h_int_n       (h_int_n),
    .l_wr_en       (l_wr_en),
    .l_addr        (l_addr),
    .l_wdata       (l_wdata),
    .l_rd_en       (l_rd_en),
    .l_rdata       (l_rdata),
    .l_irq         (l_irq),
    .hst_stat      (hst_stat),
    .lcl_stat      (lcl_stat)
);

// File: tb/mbox_irq_regfile_tb_top.sv
// Directed bench for mbox_irq_regfile. Each task runs one scenario and checks it.
module mbox_irq_regfile_tb_top;

    localparam int unsigned NUM_MBOX = 8;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned REG_W    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_wr_en = 1'b0, h_rd_en = 1'b0, h_int_disable = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic [REG_W-1:0]  h_wdata = '0;
    logic [REG_W-1:0]  h_rdata;
    logic              h_int_n;
    logic              l_wr_en = 1'b0, l_rd_en = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0;
    logic [REG_W-1:0]  l_wdata = '0;
    logic [REG_W-1:0]  l_rdata;
    logic              l_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    mbox_irq_regfile #(.NUM_MBOX(NUM_MBOX), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_int_disable(h_int_disable), .h_int_n(h_int_n),
        .l_wr_en(l_wr_en), .l_rd_en(l_rd_en), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_irq(l_irq)
    );

    function automatic logic [ADDR_W-1:0] in_off(input int n);
        return ADDR_W'(12'h800 + 4*n);
    endfunction

    function automatic logic [ADDR_W-1:0] out_off(input int n);
        return ADDR_W'(12'h900 + 4*n);
    endfunction

    task automatic check(input string req, input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic h_write(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        h_wr_en = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr_en = 1'b0;
    endtask

    task automatic l_write(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        l_wr_en = 1'b1; l_addr = a; l_wdata = d;
        @(negedge clk);
        l_wr_en = 1'b0;
    endtask

    task automatic h_read(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        @(negedge clk);
        h_rd_en = 1'b1; h_addr = a;
        @(negedge clk);
        d = h_rdata;
        h_rd_en = 1'b0;
    endtask

    task automatic l_read(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        @(negedge clk);
        l_rd_en = 1'b1; l_addr = a;
        @(negedge clk);
        d = l_rdata;
        l_rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [REG_W-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 h_int_n", REG_W'(h_int_n), 1);
        check("R1 l_irq", REG_W'(l_irq), 0);
        check("R1 h_rdata", h_rdata, 0);
        h_read(12'h040, d);   check("R1 host status", d, 0);
        l_read(12'h050, d);   check("R1 local enable", d, 0);
        h_read(in_off(0), d); check("R1 inbox0", d, 0);
    endtask

    task automatic t_inbound;
        logic [REG_W-1:0] d;
        h_write(in_off(3), 32'hA5A5_0003);
        h_write(in_off(7), 32'h1234_0007);
        h_read(in_off(3), d); check("R2 host reads inbox3", d, 32'hA5A5_0003);
        l_read(in_off(7), d); check("R2 local reads inbox7", d, 32'h1234_0007);
        l_read(12'h040, d);   check("R3 local status bits", d, 32'h88);
        l_write(in_off(3), 32'hFFFF_FFFF);
        l_read(in_off(3), d); check("R2 local write ignored", d, 32'hA5A5_0003);
        check("R8 no enable no irq", REG_W'(l_irq), 0);
    endtask

    task automatic t_outbound;
        logic [REG_W-1:0] d;
        l_write(out_off(5), 32'hCAFE_0005);
        h_read(out_off(5), d); check("R4 host reads outbox5", d, 32'hCAFE_0005);
        h_write(out_off(5), 32'h0);
        l_read(out_off(5), d); check("R4 host write ignored", d, 32'hCAFE_0005);
        h_read(12'h040, d);    check("R4 host status bit5", d, 32'h20);
        check("R7 no enable high", REG_W'(h_int_n), 1);
    endtask

    task automatic t_host_irq;
        logic [REG_W-1:0] d;
        h_write(12'h050, 32'hFFFF_FFFF);
        h_read(12'h050, d);  check("R6 upper enable bits zero", d, 32'hFF);
        check("R7 irq asserted", REG_W'(h_int_n), 0);
        @(negedge clk); h_int_disable = 1'b1;
        #1 check("R7 disable masks", REG_W'(h_int_n), 1);
        @(negedge clk); h_int_disable = 1'b0;
        #1 check("R7 re-enable", REG_W'(h_int_n), 0);
        h_write(12'h040, 32'h0000_0001);
        check("R5 clear of other bit keeps irq", REG_W'(h_int_n), 0);
        h_write(12'h040, 32'h0000_0020);
        check("R5 clear drops irq", REG_W'(h_int_n), 1);
        h_read(12'h040, d);  check("R5 host status cleared", d, 0);
    endtask

    task automatic t_local_irq;
        logic [REG_W-1:0] d;
        l_write(12'h050, 32'h08);
        check("R8 local irq on", REG_W'(l_irq), 1);
        l_write(12'h040, 32'h08);
        check("R8 local irq off", REG_W'(l_irq), 0);
        l_read(12'h040, d); check("R5 local bit3 cleared", d, 32'h80);
    endtask

    task automatic t_race;
        logic [REG_W-1:0] d;
        @(negedge clk);
        h_wr_en = 1'b1; h_addr = in_off(1); h_wdata = 32'h0000_0011;
        l_wr_en = 1'b1; l_addr = 12'h040;   l_wdata = 32'h0000_0002;
        @(negedge clk);
        h_wr_en = 1'b0; l_wr_en = 1'b0;
        l_read(12'h040, d); check("R5 set wins over clear", d, 32'h82);
    endtask

    task automatic t_unmapped;
        logic [REG_W-1:0] d;
        h_read(12'h004, d);  check("R9 unmapped low read", d, 0);
        h_read(12'h820, d);  check("R9 past last slot", d, 0);
        check("R9 idle bus zero", h_rdata, 0);
        h_write(12'h100, 32'hFFFF_FFFF);
        l_write(12'h044, 32'hFFFF_FFFF);
        l_read(12'h040, d);   check("R9 local status untouched", d, 32'h82);
        h_read(in_off(3), d); check("R9 inbox untouched", d, 32'hA5A5_0003);
        h_read(12'h040, d);   check("R9 host status untouched", d, 0);
    endtask

    initial begin
        t_reset;
        t_inbound;
        t_outbound;
        t_host_irq;
        t_local_irq;
        t_race;
        t_unmapped;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule